// File: doc/BRIEF.md
# Serial Audio Direction Control/Status Register

This block is the control and status register for one direction of a serial audio port, either transmit or receive. Software reaches it through a plain 32-bit register port with two addresses. One address holds the control bits, the interrupt enables and the status flags. The other holds the FIFO watermark. The datapath feeds the block single-cycle event strobes, an end-of-frame strobe and the current FIFO fill level. In return the block drives the datapath enable, a FIFO pointer reset pulse, a held datapath reset, a DMA request and an interrupt line.

The control/status word has a fixed layout. The control bits sit at the bottom. The five interrupt enables sit at bits 12:8. The five flags sit at bits 20:16, and each flag is exactly eight bits above its enable. Three of the flags record events and stay set until software clears them. Software clears such a flag by writing 1 to its bit. The other two flags follow the FIFO level on every cycle. Turning the direction on takes effect at once. Turning it off is deferred until the frame in progress has finished.

The parameter `DIR_TX` selects transmit or receive. It sets how the FIFO warning and FIFO request conditions are derived from the fill level.

Top module: `audio_port_csr`

## Requirements
- R1: While `rstN` is low, every stored field reads 0 at both addresses and `irq`, `dmaReq`, `xferEnable`, `fifoPtrReset` and `dpReset` are all 0.
- R2: Address 0 bit positions:
  - bit 0 is enable, bit 1 is DMA enable, bit 2 is FIFO reset and bit 3 is soft reset.
  - Bits 12:8 are the interrupt enables and bits 20:16 are the flags. Within each group the order is word-start, sync-error, FIFO-error, FIFO-warning, FIFO-request.
  - The three event flags (bits 16..18) are set one cycle after their strobe. They hold until a write to address 0 carries 1 in their bit; writing 0 leaves them unchanged.
- R3: If a clearing write and a new event for the same flag fall in the same cycle, the flag stays set.
- R4: The FIFO-warning flag (bit 19) shows, one cycle late, whether the FIFO is empty (transmit: level 0) or full (receive: level 32). Writes to bit 19 have no effect.
- R5: The FIFO-request flag (bit 20) shows, one cycle late, whether the level has reached the watermark. For transmit this means level <= watermark; for receive it means level > watermark. Writes to bit 20 have no effect.
- R6: `irq` is high exactly when some flag and its interrupt enable are both 1.
- R7: `dmaReq` is high exactly when DMA enable (bit 1) and the FIFO-request flag are both 1.
- R8: Writing enable=1 sets `xferEnable` on the next cycle. Writing enable=0 while it is set keeps it (and bit 0) at 1 until the first `frameEnd` after the write, then clears it. Writing 1 again before that `frameEnd` cancels the pending clear.
- R9: Writing 1 to bit 2 produces a single-cycle `fifoPtrReset` pulse on the next cycle. Bit 2 always reads 0.
- R10: Soft reset (bit 3) drives `dpReset` until software writes it back to 0. While it is set, the three event flags are forced to 0 from the following cycle on.
- R11: Address 1 holds the 5-bit watermark in bits 4:0. The upper bits of address 1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control/status, 1 watermark |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| evWordStart | input | 1 | Start-of-word event strobe |
| evSyncErr | input | 1 | Frame sync error event strobe |
| evFifoErr | input | 1 | Underrun (transmit) or overflow (receive) strobe |
| frameEnd | input | 1 | Last bit of the current frame |
| fifoLevel | input | 6 | FIFO fill level, 0..32 |
| irq | output | 1 | Interrupt request |
| dmaReq | output | 1 | DMA request |
| xferEnable | output | 1 | Datapath enable |
| fifoPtrReset | output | 1 | One-cycle FIFO pointer reset |
| dpReset | output | 1 | Held datapath reset |

## Verification
Internal state is visible directly at the ports, so a wrong value shows up quickly:
- A flag that is lost or stuck shows in `rdData` bits 20:16 and in `irq` one cycle after the strobe or write that should have moved it.
- A deferred disable that is mis-timed shows as `xferEnable` falling before, or staying high after, the first `frameEnd` that follows the clearing write.
- A wrong watermark comparison or wrong direction sense shows in `dmaReq` and bit 20 one cycle after the level changes.

The bench therefore compares every port on every cycle against a model derived from the requirements. It runs a transmit instance and a receive instance side by side.

// File: rtl/audio_port_csr_pkg.sv
package audio_port_csr_pkg;
  localparam int BIT_EN     = 0;
  localparam int BIT_DMA    = 1;
  localparam int BIT_FRST   = 2;
  localparam int BIT_SRST   = 3;
  localparam int IE_LSB     = 8;
  localparam int FLAG_LSB   = 16;
  localparam int NUM_FLAGS  = 5;
  localparam int NUM_STICKY = 3;
  localparam int IDX_WARN   = 3;
  localparam int IDX_REQ    = 4;

  typedef struct packed {
    logic [NUM_STICKY-1:0] clrSticky;
    logic                  holdClear;
  } csrStrobe_t;
endpackage

// File: rtl/apc_ctrl.sv
module apc_ctrl
  import audio_port_csr_pkg::*;
#(
  parameter int WM_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 addr,
  input  logic [31:0]          wrData,
  input  logic                 frameEnd,
  output csrStrobe_t           strobe,
  output logic [NUM_FLAGS-1:0] ieMask,
  output logic                 dmaEn,
  output logic                 enable,
  output logic                 swRst,
  output logic                 fifoPtrReset,
  output logic [WM_W-1:0]      watermark
);
  logic wrCsr, wrWm, offPending;
  logic unusedWrBits;

  assign wrCsr = wrEn && !addr;
  assign wrWm  = wrEn && addr;
  assign unusedWrBits = ^{wrData[31:FLAG_LSB+NUM_STICKY], wrData[IE_LSB-1:BIT_SRST+1]};

  always_comb begin
    strobe.clrSticky = wrCsr ? wrData[FLAG_LSB +: NUM_STICKY] : '0;
    strobe.holdClear = swRst;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ieMask       <= '0;
      dmaEn        <= 1'b0;
      swRst        <= 1'b0;
      fifoPtrReset <= 1'b0;
      watermark    <= '0;
      enable       <= 1'b0;
      offPending   <= 1'b0;
    end else begin
      fifoPtrReset <= wrCsr && wrData[BIT_FRST];
      if (wrCsr) begin
        ieMask <= wrData[IE_LSB +: NUM_FLAGS];
        dmaEn  <= wrData[BIT_DMA];
        swRst  <= wrData[BIT_SRST];
      end
      if (wrWm) watermark <= wrData[WM_W-1:0];
      if (wrCsr && wrData[BIT_EN]) begin
        enable     <= 1'b1;
        offPending <= 1'b0;
      end else if (offPending && frameEnd) begin
        enable     <= 1'b0;
        offPending <= 1'b0;
      end else if (wrCsr && !wrData[BIT_EN] && enable) begin
        offPending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/apc_status.sv
module apc_status
  import audio_port_csr_pkg::*;
#(
  parameter bit DIR_TX = 1'b1,
  parameter int DEPTH  = 32,
  parameter int LVL_W  = 6,
  parameter int WM_W   = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  csrStrobe_t            strobe,
  input  logic [NUM_STICKY-1:0] evt,
  input  logic [LVL_W-1:0]      fifoLevel,
  input  logic [WM_W-1:0]       watermark,
  input  logic [NUM_FLAGS-1:0]  ieMask,
  input  logic                  dmaEn,
  output logic [NUM_FLAGS-1:0]  flags,
  output logic                  irq,
  output logic                  dmaReq
);
  logic warnNext, reqNext;

  for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (!rstN || strobe.holdClear) flags[i] <= 1'b0;
      else if (evt[i])               flags[i] <= 1'b1;
      else if (strobe.clrSticky[i])  flags[i] <= 1'b0;
    end
  end

  if (DIR_TX) begin : g_tx
    assign warnNext = (fifoLevel == LVL_W'(0));
    assign reqNext  = (fifoLevel <= LVL_W'(watermark));
  end else begin : g_rx
    assign warnNext = (fifoLevel == LVL_W'(DEPTH));
    assign reqNext  = (fifoLevel > LVL_W'(watermark));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags[IDX_WARN] <= 1'b0;
      flags[IDX_REQ]  <= 1'b0;
    end else begin
      flags[IDX_WARN] <= warnNext;
      flags[IDX_REQ]  <= reqNext;
    end
  end

  assign irq    = |(flags & ieMask);
  assign dmaReq = dmaEn && flags[IDX_REQ];
endmodule

// File: rtl/audio_port_csr.sv
module audio_port_csr
  import audio_port_csr_pkg::*;
#(
  parameter bit DIR_TX = 1'b1,
  parameter int DEPTH  = 32,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int WM_W  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             addr,
  input  logic [31:0]      wrData,
  output logic [31:0]      rdData,
  input  logic             evWordStart,
  input  logic             evSyncErr,
  input  logic             evFifoErr,
  input  logic             frameEnd,
  input  logic [LVL_W-1:0] fifoLevel,
  output logic             irq,
  output logic             dmaReq,
  output logic             xferEnable,
  output logic             fifoPtrReset,
  output logic             dpReset
);
  csrStrobe_t            strobe;
  logic [NUM_FLAGS-1:0]  ieMask, flags;
  logic [NUM_STICKY-1:0] evt;
  logic [WM_W-1:0]       watermark;
  logic                  dmaEn, enable, swRst;

  assign evt = {evFifoErr, evSyncErr, evWordStart};

  apc_ctrl #(.WM_W(WM_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .frameEnd(frameEnd), .strobe(strobe), .ieMask(ieMask), .dmaEn(dmaEn),
    .enable(enable), .swRst(swRst), .fifoPtrReset(fifoPtrReset),
    .watermark(watermark)
  );

  apc_status #(.DIR_TX(DIR_TX), .DEPTH(DEPTH), .LVL_W(LVL_W), .WM_W(WM_W)) u_status (
    .clk(clk), .rstN(rstN), .strobe(strobe), .evt(evt), .fifoLevel(fifoLevel),
    .watermark(watermark), .ieMask(ieMask), .dmaEn(dmaEn), .flags(flags),
    .irq(irq), .dmaReq(dmaReq)
  );

  always_comb begin
    rdData = '0;
    if (addr) begin
      rdData[WM_W-1:0] = watermark;
    end else begin
      rdData[BIT_EN]                 = enable;
      rdData[BIT_DMA]                = dmaEn;
      rdData[BIT_SRST]               = swRst;
      rdData[IE_LSB +: NUM_FLAGS]    = ieMask;
      rdData[FLAG_LSB +: NUM_FLAGS]  = flags;
    end
  end

  assign xferEnable = enable;
  assign dpReset    = swRst;
endmodule

// File: rtl/audio_port_csr_checker.sv
module audio_port_csr_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       addr,
  input logic       frstBit,
  input logic [2:0] evt,
  input logic       frameEnd,
  input logic [4:0] flags,
  input logic       swRst,
  input logic       dmaEn,
  input logic       enable,
  input logic       fifoPtrReset,
  input logic       dmaReq
);
  // R2: event flags only fall through a control write or soft reset
  p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!swRst && !(wrEn && !addr)) |=> ((flags[2:0] & $past(flags[2:0])) == $past(flags[2:0])));

  // R3: a new event always lands, whatever the write does
  p_event_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!swRst && (|evt)) |=> ((flags[2:0] & $past(evt)) == $past(evt)));

  // R7: a DMA request needs both the enable and the request flag
  p_dma_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> (dmaEn && flags[4]));

  // R8: the direction only switches off on a frame boundary
  p_off_at_frame_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enable) |-> $past(frameEnd));

  // R9: pointer reset pulse follows a control write with bit 2 set
  p_frst_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    fifoPtrReset |-> $past(wrEn && !addr && frstBit));

  // R10: soft reset empties the event flags
  p_swrst_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    swRst |=> (flags[2:0] == 3'b000));
endmodule

bind audio_port_csr audio_port_csr_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .frstBit(wrData[2]),
  .evt(evt), .frameEnd(frameEnd), .flags(flags), .swRst(swRst),
  .dmaEn(dmaEn), .enable(enable), .fifoPtrReset(fifoPtrReset), .dmaReq(dmaReq)
);

// File: tb/audio_port_csr_test.sv
`timescale 1ns/1ps
module audio_port_csr_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, addr = 1'b0, frameEnd = 1'b0;
  logic [31:0] wrData = '0;
  logic [2:0] evt = '0;
  logic [5:0] fifoLevel = 6'd5;
  logic [31:0] rdTx, rdRx;
  logic irqTx, irqRx, dmaTx, dmaRx, enTx, enRx, frTx, frRx, drTx, drRx;
  int checks = 0, errors = 0;

  // model state
  logic [2:0] mSticky = '0;
  logic [4:0] mIe = '0, mWm = '0;
  logic mDma = 0, mEn = 0, mPend = 0, mSrst = 0, mFrst = 0;
  logic [1:0] liveTx = '0, liveRx = '0;   // {req, warn}

  always #2 clk = ~clk;

  audio_port_csr #(.DIR_TX(1'b1)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdTx),
    .evWordStart(evt[0]), .evSyncErr(evt[1]), .evFifoErr(evt[2]), .frameEnd(frameEnd),
    .fifoLevel(fifoLevel), .irq(irqTx), .dmaReq(dmaTx), .xferEnable(enTx),
    .fifoPtrReset(frTx), .dpReset(drTx));

  audio_port_csr #(.DIR_TX(1'b0)) uutRx (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdRx),
    .evWordStart(evt[0]), .evSyncErr(evt[1]), .evFifoErr(evt[2]), .frameEnd(frameEnd),
    .fifoLevel(fifoLevel), .irq(irqRx), .dmaReq(dmaRx), .xferEnable(enRx),
    .fifoPtrReset(frRx), .dpReset(drRx));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expImg(input logic [1:0] live, input logic sel);
    logic [31:0] v = '0;
    if (sel) v[4:0] = mWm;
    else begin
      v[0] = mEn; v[1] = mDma; v[3] = mSrst;
      v[12:8] = mIe; v[20:16] = {live, mSticky};
    end
    return v;
  endfunction

  function automatic logic expIrq(input logic [1:0] live);
    return |({live, mSticky} & mIe);
  endfunction

  task automatic modelStep(input logic w, input logic a, input logic [31:0] d,
                           input logic [2:0] e, input logic fe, input logic [5:0] lvl);
    logic wr = w && !a;
    for (int i = 0; i < 3; i++) begin
      if (mSrst) mSticky[i] = 1'b0;
      else if (e[i]) mSticky[i] = 1'b1;
      else if (wr && d[16+i]) mSticky[i] = 1'b0;
    end
    liveTx = {lvl <= {1'b0, mWm}, lvl == 6'd0};
    liveRx = {lvl > {1'b0, mWm}, lvl == 6'd32};
    if (wr && d[0]) begin mEn = 1; mPend = 0; end
    else if (mPend && fe) begin mEn = 0; mPend = 0; end
    else if (wr && !d[0] && mEn) mPend = 1;
    mFrst = wr && d[2];
    if (wr) begin mIe = d[12:8]; mDma = d[1]; mSrst = d[3]; end
    if (w && a) mWm = d[4:0];
  endtask

  task automatic checkAll(input string ph, input logic sel);
    chk({ph, " R2/R3/R4/R5/R8/R10/R11 tx image"}, rdTx, expImg(liveTx, sel));
    chk({ph, " R4/R5 rx image"}, rdRx, expImg(liveRx, sel));
    chk({ph, " R6 irq tx"}, 32'(irqTx), 32'(expIrq(liveTx)));
    chk({ph, " R6 irq rx"}, 32'(irqRx), 32'(expIrq(liveRx)));
    chk({ph, " R7 dma tx"}, 32'(dmaTx), 32'(mDma && liveTx[1]));
    chk({ph, " R7 dma rx"}, 32'(dmaRx), 32'(mDma && liveRx[1]));
    chk({ph, " R8 enable"}, 32'(enTx), 32'(mEn));
    chk({ph, " R9 fifo reset pulse"}, 32'(frTx), 32'(mFrst));
    chk({ph, " R10 datapath reset"}, 32'(drTx), 32'(mSrst));
  endtask

  task automatic cyc(input string ph, input logic w, input logic a, input logic [31:0] d,
                     input logic [2:0] e, input logic fe, input logic [5:0] lvl, input logic sel);
    wrEn = w; addr = a; wrData = d; evt = e; frameEnd = fe; fifoLevel = lvl;
    @(posedge clk);
    modelStep(w, a, d, e, fe, lvl);
    #1;
    wrEn = 0; addr = sel; evt = '0; frameEnd = 0; wrData = '0;
    #0.5;
    checkAll(ph, sel);
  endtask

  task automatic idle(input string ph, input int n, input logic [5:0] lvl);
    for (int k = 0; k < n; k++) cyc(ph, 0, 0, '0, '0, 0, lvl, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    // R1: everything zero in reset
    addr = 0; #0.5;
    chk("R1 reset image tx", rdTx, 32'h0);
    chk("R1 reset image rx", rdRx, 32'h0);
    chk("R1 reset outputs", 32'({irqTx, dmaTx, enTx, frTx, drTx, irqRx, dmaRx}), 32'h0);
    addr = 1; #0.1;
    chk("R1 reset watermark", rdTx, 32'h0);
    addr = 0;
    rstN = 1;

    // R11: watermark, upper bits dropped
    cyc("R11", 1, 1, 32'hFFFF_FFE8, '0, 0, 6'd5, 1);
    // R2: event set, write 0 keeps, write 1 clears
    cyc("R2 set", 0, 0, '0, 3'b101, 0, 6'd5, 0);
    cyc("R2 w0 keeps", 1, 0, 32'h0000_0000, '0, 0, 6'd5, 0);
    cyc("R2 w1c", 1, 0, 32'h0001_0000, '0, 0, 6'd5, 0);
    // R3: collision, event wins
    cyc("R3 collide", 1, 0, 32'h0007_0000, 3'b010, 0, 6'd5, 0);
    // R4/R5: writes to live bits ignored; level sweep around watermark 8
    cyc("R4 write live", 1, 0, 32'h0018_1F02, '0, 0, 6'd0, 0);
    idle("R4 empty", 1, 6'd0);
    idle("R5 at wm", 2, 6'd8);
    idle("R5 above wm", 2, 6'd9);
    idle("R4 full", 2, 6'd32);
    // R6: irq with selective enables
    cyc("R6 ie", 1, 0, 32'h0000_0400, 3'b100, 0, 6'd9, 0);
    // R8: deferred disable and cancel
    cyc("R8 on", 1, 0, 32'h0000_0001, '0, 0, 6'd9, 0);
    cyc("R8 off req", 1, 0, 32'h0000_0000, '0, 1, 6'd9, 0);
    idle("R8 pending", 3, 6'd9);
    cyc("R8 frame end", 0, 0, '0, '0, 1, 6'd9, 0);
    idle("R8 off", 1, 6'd9);
    cyc("R8 on2", 1, 0, 32'h0000_0001, '0, 0, 6'd9, 0);
    cyc("R8 off2", 1, 0, 32'h0000_0000, '0, 0, 6'd9, 0);
    cyc("R8 cancel", 1, 0, 32'h0000_0001, '0, 0, 6'd9, 0);
    cyc("R8 frame no drop", 0, 0, '0, '0, 1, 6'd9, 0);
    // R9: pointer reset pulse
    cyc("R9 pulse", 1, 0, 32'h0000_0005, '0, 0, 6'd3, 0);
    idle("R9 after", 1, 6'd3);
    // R10: soft reset holds flags clear
    cyc("R10 on", 1, 0, 32'h0000_0009, 3'b111, 0, 6'd3, 0);
    cyc("R10 hold", 0, 0, '0, 3'b111, 0, 6'd3, 0);
    cyc("R10 off", 1, 0, 32'h0000_0001, 3'b011, 0, 6'd3, 0);
    idle("R10 after", 1, 6'd3);

    // random mix
    for (int n = 0; n < 1500; n++) begin
      logic w = ($urandom % 4) == 0;
      logic a = ($urandom % 8) == 0;
      logic [31:0] d = $urandom;
      logic [2:0] e;
      if (($urandom % 10) != 0) d[3] = 1'b0;
      e[0] = ($urandom % 5) == 0;
      e[1] = ($urandom % 7) == 0;
      e[2] = ($urandom % 9) == 0;
      cyc("rand", w, a, d, e, ($urandom % 6) == 0, 6'($urandom % 33), 1'($urandom % 4 == 0));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule